// File: doc/BRIEF.md
# Multi-Output PWM Generator with Dead Band

This block produces pulse-width modulated waveforms from a free-running 8-bit period counter. Two low-order phase bits extend the counter to a 10-bit time base, so the duty value has four times the resolution of the period value. A clock prescaler in front of the time base divides the input clock by 1, 4 or 16. One modulated signal is produced per period and steered to four outputs according to a 2-bit steering field. Each output has its own active level. In half-bridge steering the two complementary outputs get a programmable dead band on their rising edges.

Software-visible settings arrive through a simple write port and are first held in pending registers. Period, duty, steering, polarity and prescale reach the active side only at a period boundary, so a waveform never changes shape mid-period. The dead-band count takes effect at the first duty boundary or period boundary after it is written. A one-clock strobe marks each period boundary so that other logic can update settings in step with the waveform.

Top module: `epwm_gen`

## Requirements
- R1: The period is (P+1)*4*S input clocks, where P is the period register and S the prescale divisor. `period_strobe_o` is high for exactly one clock at each period boundary.
- R2: The modulated signal is active for D*S clocks per period, where D is the 10-bit duty value. D = 0 gives no active time. D >= 4*(P+1) gives the whole period.
- R3: Period, duty, steering, polarity and prescale writes made while running leave the current period unchanged and apply from the next strobe.
- R4: While the enable bit is 0, all outputs sit at their inactive level and no strobe occurs. After a write of enable = 1, the first strobe comes in the second clock after the write edge. The outputs follow one clock after the strobe.
- R5: Steering field 0 drives the modulated signal on output 0. Field 1 holds output 0 active and modulates output 3. Field 2 puts complementary signals on outputs 0 and 1. Field 3 holds output 2 active and modulates output 1. Any output not named in the selected mode stays inactive.
- R6: Polarity bit i = 0 makes output i active-high. Polarity bit i = 1 makes it active-low, so its inactive level is 1.
- R7: In steering mode 2 with dead-band count B, each rising edge of the two complementary signals is delayed B clocks. Output 0 is then active D*S-B clocks per period and output 1 is active (period - D*S) - B clocks.
- R8: A dead-band count written while running is first used by the rising edge that follows the next duty boundary or period boundary, whichever comes first.
- R9: Prescale select 0 divides by 1, select 1 by 4, and selects 2 and 3 by 16.
- R10: Out of reset, all four outputs and the strobe are 0.
- R11: Write port addresses are 0 period, 1 duty, 2 steering, 3 polarity, 4 dead-band count, 5 prescale select and 6 enable (data bit 0). A write is taken at a rising clock edge where `wr_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 10 | Write data, low bits used per register |
| pwm_o | output | 4 | Steered, polarity-adjusted PWM outputs |
| period_strobe_o | output | 1 | One-clock pulse at each period boundary |

## Verification
The bench counts active clocks over whole periods and compares them with values derived from the period, duty, prescale and dead-band settings. This covers the 0% and saturated duty extremes: a design that set the output at a zero duty would show a sliver of active time, and one that compared against a wrapped duty would fall short of 100%. Mid-period writes of duty and period check double buffering, since a design without shadow registers would show the new value one period early. A dead-band count written between the period start and the duty boundary separates the early-load rule from both immediate loading and period-only loading. The bench also checks the exact start-up latency after enable and the idle levels under mixed polarities.

// File: rtl/epwm_pkg.sv
package epwm_pkg;

    localparam int unsigned NUM_OUT = 4;
    localparam int unsigned PRE_W   = 4;

    typedef enum logic [1:0] {
        STEER_SINGLE = 2'd0,
        STEER_FWD    = 2'd1,
        STEER_HALF   = 2'd2,
        STEER_REV    = 2'd3
    } steer_e;

    typedef enum logic [2:0] {
        ADDR_PERIOD = 3'd0,
        ADDR_DUTY   = 3'd1,
        ADDR_STEER  = 3'd2,
        ADDR_POL    = 3'd3,
        ADDR_DBAND  = 3'd4,
        ADDR_PSC    = 3'd5,
        ADDR_EN     = 3'd6
    } addr_e;

    typedef struct packed {
        steer_e               steer;
        logic [NUM_OUT-1:0]   pol;
        logic [1:0]           psc;
    } shape_t;

    // Number of input clocks per time-base tick for a prescale select.
    function automatic logic [PRE_W:0] psc_ticks(input logic [1:0] sel);
        case (sel)
            2'd0:    psc_ticks = (PRE_W+1)'(1);
            2'd1:    psc_ticks = (PRE_W+1)'(4);
            default: psc_ticks = (PRE_W+1)'(16);
        endcase
    endfunction

endpackage

// File: rtl/epwm_regs.sv
module epwm_regs
    import epwm_pkg::*;
#(
    parameter int unsigned TMR_W  = 8,
    parameter int unsigned DB_W   = 6,
    localparam int unsigned DUTY_W = TMR_W + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [DUTY_W-1:0] wr_data_i,
    input  logic              run_i,
    input  logic              bnd_i,
    input  logic              hit_i,
    output logic              en_o,
    output logic [TMR_W-1:0]  prd_o,
    output logic [DUTY_W-1:0] duty_act_o,
    output logic [DUTY_W-1:0] duty_pend_o,
    output shape_t            shape_o,
    output logic [DB_W-1:0]   db_o
);

    typedef struct packed {
        logic              en;
        logic [TMR_W-1:0]  prd_p;
        logic [TMR_W-1:0]  prd_a;
        logic [DUTY_W-1:0] duty_p;
        logic [DUTY_W-1:0] duty_a;
        shape_t            shp_p;
        shape_t            shp_a;
        logic [DB_W-1:0]   db_p;
        logic [DB_W-1:0]   db_a;
    } regs_t;

    regs_t q, d;
    logic  load_main;
    logic  load_db;

    always_comb begin
        d = q;
        if (wr_en_i) begin
            case (addr_e'(wr_addr_i))
                ADDR_PERIOD: d.prd_p     = wr_data_i[TMR_W-1:0];
                ADDR_DUTY:   d.duty_p    = wr_data_i;
                ADDR_STEER:  d.shp_p.steer = steer_e'(wr_data_i[1:0]);
                ADDR_POL:    d.shp_p.pol = wr_data_i[NUM_OUT-1:0];
                ADDR_DBAND:  d.db_p      = wr_data_i[DB_W-1:0];
                ADDR_PSC:    d.shp_p.psc = wr_data_i[1:0];
                ADDR_EN:     d.en        = wr_data_i[0];
                default: ;
            endcase
        end
        // Idle: active side tracks pending. Running: only at boundaries.
        load_main = bnd_i || !run_i;
        load_db   = load_main || hit_i;
        if (load_main) begin
            d.prd_a  = q.prd_p;
            d.duty_a = q.duty_p;
            d.shp_a  = q.shp_p;
        end
        if (load_db) begin
            d.db_a = q.db_p;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign en_o        = q.en;
    assign prd_o       = q.prd_a;
    assign duty_act_o  = q.duty_a;
    assign duty_pend_o = q.duty_p;
    assign shape_o     = q.shp_a;
    assign db_o        = q.db_a;

    // R3: active settings hold between boundaries while running
    a_r3_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !bnd_i) |=> (q.duty_a == $past(q.duty_a) && q.prd_a == $past(q.prd_a)
                               && q.shp_a == $past(q.shp_a)));

    // R8: dead band changes only at a duty or period boundary while running
    a_r8_db_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !bnd_i && !hit_i) |=> (q.db_a == $past(q.db_a)));

endmodule

// File: rtl/epwm_timebase.sv
module epwm_timebase
    import epwm_pkg::*;
#(
    parameter int unsigned TMR_W = 8,
    localparam int unsigned TB_W = TMR_W + 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [TMR_W-1:0] prd_i,
    input  logic [1:0]       psc_i,
    output logic             run_o,
    output logic             bnd_o,
    output logic             strobe_o,
    output logic [TB_W-1:0]  tb_next_o
);

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [1:0]       ph;
        logic [TMR_W-1:0] tmr;
        logic             stb;
    } tb_t;

    tb_t            q, d;
    logic [PRE_W:0] lim;
    logic           pre_last;
    logic           wrap;
    logic           bnd;

    always_comb begin
        d        = q;
        d.stb    = 1'b0;
        lim      = psc_ticks(psc_i) - 1'b1;
        pre_last = ({1'b0, q.pre} == lim);
        wrap     = q.run && pre_last && (q.ph == 2'd3) && (q.tmr == prd_i);
        bnd      = en_i && (!q.run || wrap);
        if (!en_i) begin
            d.run = 1'b0;
            d.pre = '0;
            d.ph  = '0;
            d.tmr = '0;
        end else if (bnd) begin
            d.run = 1'b1;
            d.pre = '0;
            d.ph  = '0;
            d.tmr = '0;
            d.stb = 1'b1;
        end else if (pre_last) begin
            d.pre = '0;
            d.ph  = q.ph + 2'd1;
            if (q.ph == 2'd3) d.tmr = q.tmr + 1'b1;
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign run_o     = q.run;
    assign bnd_o     = bnd;
    assign strobe_o  = q.stb;
    assign tb_next_o = {d.tmr, d.ph};

    // R1: the strobe never lasts longer than one clock
    a_r1_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.stb |=> !q.stb);

    // R1: the counter never passes the active period value
    a_r1_tmr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.run |-> (q.tmr <= prd_i));

    // R4: running starts only together with a boundary strobe
    a_r4_start_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.run) |-> q.stb);

endmodule

// File: rtl/epwm_modulator.sv
module epwm_modulator
    import epwm_pkg::*;
#(
    parameter int unsigned TMR_W = 8,
    parameter int unsigned DB_W  = 6,
    localparam int unsigned TB_W = TMR_W + 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               bnd_i,
    input  logic [TB_W-1:0]    tb_next_i,
    input  logic [TB_W-1:0]    duty_act_i,
    input  logic [TB_W-1:0]    duty_pend_i,
    input  steer_e             steer_i,
    input  logic [NUM_OUT-1:0] pol_i,
    input  logic [DB_W-1:0]    db_i,
    output logic               hit_o,
    output logic [NUM_OUT-1:0] pwm_o
);

    typedef struct packed {
        logic               mod;
        logic [DB_W-1:0]    dly;
        logic [NUM_OUT-1:0] out;
    } mod_t;

    mod_t               q, d;
    logic               hit;
    logic               settled;
    logic [NUM_OUT-1:0] act;
    logic [NUM_OUT-1:0] lvl;

    // Per-output level selection.
    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_pol
        assign lvl[gi] = act[gi] ^ pol_i[gi];
    end

    always_comb begin
        d   = q;
        hit = run_i && !bnd_i && q.mod && (tb_next_i == duty_act_i);

        if (bnd_i)       d.mod = (duty_pend_i != '0);
        else if (!run_i) d.mod = 1'b0;
        else if (hit)    d.mod = 1'b0;

        if (d.mod != q.mod)   d.dly = db_i;
        else if (q.dly != '0) d.dly = q.dly - 1'b1;

        settled = (q.dly == '0);
        act     = '0;
        if (run_i) begin
            case (steer_i)
                STEER_SINGLE: act[0] = q.mod;
                STEER_FWD: begin
                    act[0] = 1'b1;
                    act[3] = q.mod;
                end
                STEER_HALF: begin
                    act[0] = q.mod && settled;
                    act[1] = !q.mod && settled;
                end
                STEER_REV: begin
                    act[2] = 1'b1;
                    act[1] = q.mod;
                end
                default: act = '0;
            endcase
        end
        d.out = lvl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign hit_o = hit;
    assign pwm_o = q.out;

    // R4: when not running every output sits at its inactive level
    a_r4_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (q.out == $past(pol_i)));

    // R7: the complementary pair is never active together
    a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && steer_i == STEER_HALF) |=>
            !((q.out[0] ^ $past(pol_i[0])) && (q.out[1] ^ $past(pol_i[1]))));

    // R5: single-output steering leaves outputs 1..3 inactive
    a_r5_single_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && steer_i == STEER_SINGLE) |=> (q.out[3:1] == $past(pol_i[3:1])));

    // R2: a zero duty never starts an active phase
    a_r2_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bnd_i && duty_pend_i == '0) |=> !q.mod);

endmodule

// File: rtl/epwm_gen.sv
module epwm_gen
    import epwm_pkg::*;
#(
    parameter int unsigned TMR_W = 8,
    parameter int unsigned DB_W  = 6,
    localparam int unsigned DUTY_W = TMR_W + 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_addr_i,
    input  logic [DUTY_W-1:0]  wr_data_i,
    output logic [NUM_OUT-1:0] pwm_o,
    output logic               period_strobe_o
);

    logic              en;
    logic              run;
    logic              bnd;
    logic              hit;
    logic [TMR_W-1:0]  prd_a;
    logic [DUTY_W-1:0] duty_a;
    logic [DUTY_W-1:0] duty_p;
    shape_t            shape_a;
    logic [DB_W-1:0]   db_a;
    logic [DUTY_W-1:0] tb_next;

    epwm_regs #(.TMR_W(TMR_W), .DB_W(DB_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .run_i       (run),
        .bnd_i       (bnd),
        .hit_i       (hit),
        .en_o        (en),
        .prd_o       (prd_a),
        .duty_act_o  (duty_a),
        .duty_pend_o (duty_p),
        .shape_o     (shape_a),
        .db_o        (db_a)
    );

    epwm_timebase #(.TMR_W(TMR_W)) u_tb (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en),
        .prd_i     (prd_a),
        .psc_i     (shape_a.psc),
        .run_o     (run),
        .bnd_o     (bnd),
        .strobe_o  (period_strobe_o),
        .tb_next_o (tb_next)
    );

    epwm_modulator #(.TMR_W(TMR_W), .DB_W(DB_W)) u_mod (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run),
        .bnd_i       (bnd),
        .tb_next_i   (tb_next),
        .duty_act_i  (duty_a),
        .duty_pend_i (duty_p),
        .steer_i     (shape_a.steer),
        .pol_i       (shape_a.pol),
        .db_i        (db_a),
        .hit_o       (hit),
        .pwm_o       (pwm_o)
    );

endmodule

// File: tb/epwm_gen_tb.sv
module epwm_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic [3:0] pwm;
    logic       strobe;

    int checks = 0;
    int errors = 0;
    int hi [4];
    int per;

    always #(CLK_PERIOD/2) clk = ~clk;

    epwm_gen u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .wr_en_i         (wr_en),
        .wr_addr_i       (wr_addr),
        .wr_data_i       (wr_data),
        .pwm_o           (pwm),
        .period_strobe_o (strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 10'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic sync_strobe();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (strobe) return;
        end
        check("R1 strobe seen", 0, 1);
    endtask

    // Count active clocks of each output over one period starting at a strobe.
    // Optionally issue one write at clock offset wr_at inside the period.
    task automatic run_period(input int wr_at, input int addr, input int data);
        per = 0;
        for (int j = 0; j < 4; j++) hi[j] = 0;
        do begin
            @(negedge clk);
            per++;
            if (per == wr_at) begin
                wr_en   = 1'b1;
                wr_addr = 3'(addr);
                wr_data = 10'(data);
            end else begin
                wr_en = 1'b0;
            end
            for (int j = 0; j < 4; j++) hi[j] += int'(pwm[j]);
        end while (!strobe && per < 5000);
        wr_en = 1'b0;
    endtask

    task automatic configure(input int prd, input int duty, input int steer,
                             input int pol, input int db, input int psc);
        wr(6, 0);
        wr(0, prd);
        wr(1, duty);
        wr(2, steer);
        wr(3, pol);
        wr(4, db);
        wr(5, psc);
        wr(6, 1);
        sync_strobe();
        run_period(-1, 0, 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 outputs after reset", int'(pwm), 0);
            check("R10 strobe after reset", int'(strobe), 0);
        end
    endtask

    task automatic t_basic();
        configure(9, 13, 0, 0, 0, 0);
        run_period(-1, 0, 0);
        check("R1 period prd=9 div1", per, 40);
        check("R2 active out0 duty=13", hi[0], 13);
        check("R5 single out1", hi[1], 0);
        check("R5 single out3", hi[3], 0);
        check("R11 write port addresses", hi[0] + per, 53);
        configure(0, 2, 0, 0, 0, 0);
        run_period(-1, 0, 0);
        check("R1 period prd=0", per, 4);
        check("R2 active prd=0 duty=2", hi[0], 2);
    endtask

    task automatic t_duty_edges();
        configure(9, 0, 0, 0, 0, 0);
        run_period(-1, 0, 0);
        check("R2 zero duty", hi[0], 0);
        configure(9, 1023, 0, 0, 0, 0);
        run_period(-1, 0, 0);
        check("R2 saturated duty", hi[0], 40);
        configure(9, 40, 0, 0, 0, 0);
        run_period(-1, 0, 0);
        check("R2 duty equals period", hi[0], 40);
    endtask

    task automatic t_prescale();
        configure(4, 7, 0, 0, 0, 1);
        run_period(-1, 0, 0);
        check("R9 period div4", per, 80);
        check("R9 active div4", hi[0], 28);
        configure(1, 5, 0, 0, 0, 2);
        run_period(-1, 0, 0);
        check("R9 period div16", per, 128);
        check("R9 active div16", hi[0], 80);
        configure(1, 5, 0, 0, 0, 3);
        run_period(-1, 0, 0);
        check("R9 period sel3", per, 128);
        check("R1 active sel3", hi[0], 80);
    endtask

    task automatic t_buffering();
        configure(9, 20, 0, 0, 0, 0);
        run_period(3, 1, 6);
        check("R3 duty held this period", hi[0], 20);
        run_period(-1, 0, 0);
        check("R3 duty applied next period", hi[0], 6);
        run_period(3, 0, 4);
        check("R3 period held this period", per, 40);
        run_period(-1, 0, 0);
        check("R3 period applied next period", per, 20);
        check("R3 duty with new period", hi[0], 6);
        run_period(2, 2, 3);
        check("R3 steer held this period", hi[0], 6);
        run_period(-1, 0, 0);
        check("R3 steer applied out2", hi[2], 20);
    endtask

    task automatic t_steer();
        configure(9, 13, 1, 0, 0, 0);
        run_period(-1, 0, 0);
        check("R5 fwd out0 held", hi[0], 40);
        check("R5 fwd out3 mod", hi[3], 13);
        check("R5 fwd out1 idle", hi[1], 0);
        check("R5 fwd out2 idle", hi[2], 0);
        configure(9, 13, 3, 0, 0, 0);
        run_period(-1, 0, 0);
        check("R5 rev out2 held", hi[2], 40);
        check("R5 rev out1 mod", hi[1], 13);
        check("R5 rev out0 idle", hi[0], 0);
        check("R5 rev out3 idle", hi[3], 0);
    endtask

    task automatic t_polarity();
        wr(6, 0);
        wr(0, 9);
        wr(1, 13);
        wr(2, 0);
        wr(3, 10);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R6 idle levels", int'(pwm), 10);
        wr(6, 1);
        sync_strobe();
        run_period(-1, 0, 0);
        run_period(-1, 0, 0);
        check("R6 out0 active high", hi[0], 13);
        check("R6 out1 active low idle", hi[1], 40);
        check("R6 out2 active high idle", hi[2], 0);
        check("R6 out3 active low idle", hi[3], 40);
        configure(9, 13, 0, 1, 0, 0);
        run_period(-1, 0, 0);
        check("R6 out0 active low high time", hi[0], 27);
    endtask

    task automatic t_deadband();
        configure(9, 13, 2, 0, 0, 0);
        run_period(-1, 0, 0);
        check("R7 half db0 out0", hi[0], 13);
        check("R7 half db0 out1", hi[1], 27);
        configure(9, 13, 2, 0, 3, 0);
        run_period(-1, 0, 0);
        check("R7 half db3 out0", hi[0], 10);
        check("R7 half db3 out1", hi[1], 24);
        check("R7 half out2 idle", hi[2], 0);
        configure(1, 3, 2, 0, 2, 1);
        run_period(-1, 0, 0);
        check("R7 half div4 out0", hi[0], 10);
        check("R7 half div4 out1", hi[1], 18);
    endtask

    task automatic t_db_load();
        configure(9, 13, 2, 0, 2, 0);
        run_period(-1, 0, 0);
        check("R8 base out0", hi[0], 11);
        run_period(2, 4, 5);
        check("R8 this period out0", hi[0], 11);
        check("R8 falling edge keeps old delay", hi[1], 25);
        run_period(-1, 0, 0);
        check("R8 new delay after duty boundary", hi[0], 8);
        check("R8 new delay out1", hi[1], 22);
    endtask

    task automatic t_enable();
        wr(6, 0);
        wr(0, 9);
        wr(1, 13);
        wr(2, 0);
        wr(3, 0);
        wr(4, 0);
        wr(5, 0);
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R4 disabled outputs", int'(pwm), 0);
        wr(6, 1);
        check("R4 no strobe first clock", int'(strobe), 0);
        @(negedge clk);
        check("R4 strobe second clock", int'(strobe), 1);
        check("R4 output still idle at strobe", int'(pwm), 0);
        @(negedge clk);
        check("R4 output active after strobe", int'(pwm), 1);
        wr(6, 0);
        @(negedge clk);
        @(negedge clk);
        per = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            per += int'(strobe) + int'(pwm != 4'd0);
        end
        check("R4 stopped after disable", per, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_duty_edges();
        t_prescale();
        t_buffering();
        t_steer();
        t_polarity();
        t_deadband();
        t_db_load();
        t_enable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule